// File: doc/BRIEF.md
# Dual Clock Divider

This block derives two slower clocks from two unrelated source clocks. Output A is taken from the system bus clock and divides it by an even ratio. Output B is taken from a dedicated PLL clock and divides it by any ratio from 2 to 16. Each output has its own 4-bit setting. A setting of zero routes the source clock straight through, without division. Because each output only divides its own source, changing a source frequency changes the output frequency in the same ratio.

A divided output period always begins with its low phase and ends on its falling edge. The block loads a new setting only at that falling edge, so a setting written mid-period never shortens or stretches a pulse. Reset clears both dividers and keeps both outputs low. After reset, each divided output produces a full low phase before its first rising edge.

Top module: `clkdiv_pair`

## Requirements
- R1: While `rst_n` is low, `clk_a_out` and `clk_b_out` are both low, whatever the settings and source clocks do.
- R2: With `div_a` = 0 in effect, `clk_a_out` follows `bus_clk`: high while it is high, low while it is low.
- R3: With `div_a` = N (1 to 15) in effect, `clk_a_out` has a period of 2N `bus_clk` cycles, made of N cycles high and N cycles low.
- R4: With `div_b` = 0 in effect, `clk_b_out` follows `pll_clk`.
- R5: With `div_b` = N (1 to 15) in effect, `clk_b_out` has a period of N+1 `pll_clk` cycles. Its low phase lasts floor((N+1)/2) cycles and its high phase lasts the rest, so for odd N+1 the high phase is one cycle longer.
- R6: The output period in time is the source period times the divide ratio, so it scales when the source period changes.
- R7: A divided period runs low phase first, then high phase. A setting that changes during a period takes effect only after that period's falling edge; the period in progress completes with the old setting.
- R8: The setting present at the source edge that produces a falling edge is the one used for the very next period.
- R9: After `rst_n` rises with `div_a` = N, `clk_a_out` stays low for exactly N `bus_clk` cycles, counted from the first `bus_clk` rising edge, before it first rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Source clock for output A |
| pll_clk | input | 1 | Source clock for output B |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_a | input | 4 | Setting for output A: 0 = pass through, N = divide by 2N |
| div_b | input | 4 | Setting for output B: 0 = pass through, N = divide by N+1 |
| clk_a_out | output | 1 | Derived clock A |
| clk_b_out | output | 1 | Derived clock B |

## Verification
Two events can fall on the same source edge: a setting changes, and the current period ends and reloads its setting. The bench provokes this in both domains. It writes a new value just after the last high sample of a period, so the next rising source edge is both the falling edge and the reload. It then checks that the following low and high phases already have the new lengths. A second scenario writes the new value one sample into the low phase. There, the bench requires one more full period at the old lengths before the new lengths appear.

// File: rtl/clkdiv_pair.sv
module clkdiv_pair #(
  parameter int W = 4
) (
  input  logic         bus_clk,
  input  logic         pll_clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_a,
  input  logic [W-1:0] div_b,
  output logic         clk_a_out,
  output logic         clk_b_out
);

  localparam logic [W-1:0] ONE   = 1;
  localparam logic [W:0]   ONE_X = 1;

  logic [W-1:0] cur_a, cnt_a;
  logic         q_a, run_a, byp_a;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_a <= '0;
      cnt_a <= '0;
      q_a   <= 1'b0;
      run_a <= 1'b0;
    end else begin
      run_a <= 1'b1;
      if (cur_a == '0) begin
        cnt_a <= '0;
        q_a   <= 1'b0;
        cur_a <= div_a;
      end else if (cnt_a == cur_a - ONE) begin
        cnt_a <= '0;
        q_a   <= ~q_a;
        if (q_a) cur_a <= div_a;
      end else begin
        cnt_a <= cnt_a + ONE;
      end
    end
  end

  always_ff @(negedge bus_clk or negedge rst_n) begin
    if (!rst_n) byp_a <= 1'b0;
    else        byp_a <= run_a && (cur_a == '0);
  end

  assign clk_a_out = byp_a ? bus_clk : q_a;

  logic [W-1:0] cur_b, cnt_b;
  logic         q_b, run_b, byp_b;
  logic [W:0]   ratio_b, lo_b, hi_b, cnt_bx;

  assign ratio_b = {1'b0, cur_b} + ONE_X;
  assign lo_b    = ratio_b >> 1;
  assign hi_b    = ratio_b - lo_b;
  assign cnt_bx  = {1'b0, cnt_b};

  always_ff @(posedge pll_clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_b <= '0;
      cnt_b <= '0;
      q_b   <= 1'b0;
      run_b <= 1'b0;
    end else begin
      run_b <= 1'b1;
      if (cur_b == '0) begin
        cnt_b <= '0;
        q_b   <= 1'b0;
        cur_b <= div_b;
      end else if (!q_b) begin
        if (cnt_bx == lo_b - ONE_X) begin
          cnt_b <= '0;
          q_b   <= 1'b1;
        end else begin
          cnt_b <= cnt_b + ONE;
        end
      end else if (cnt_bx == hi_b - ONE_X) begin
        cnt_b <= '0;
        q_b   <= 1'b0;
        cur_b <= div_b;
      end else begin
        cnt_b <= cnt_b + ONE;
      end
    end
  end

  always_ff @(negedge pll_clk or negedge rst_n) begin
    if (!rst_n) byp_b <= 1'b0;
    else        byp_b <= run_b && (cur_b == '0);
  end

  assign clk_b_out = byp_b ? pll_clk : q_b;

endmodule

// File: rtl/clkdiv_pair_chk.sv
module clkdiv_pair_chk #(
  parameter int W = 4
) (
  input logic         bus_clk,
  input logic         pll_clk,
  input logic         rst_n,
  input logic [W-1:0] cur_a,
  input logic [W-1:0] cur_b,
  input logic         q_a,
  input logic         q_b,
  input logic         clk_a_out,
  input logic         clk_b_out
);

  logic [W-1:0] cp_a, cp_b;
  logic         qp_a, qp_b, seen_a, seen_b;
  logic [7:0]   len_a, len_b;

  function automatic int lo_of(input logic [W-1:0] n);
    return (int'(n) + 1) / 2;
  endfunction

  function automatic int hi_of(input logic [W-1:0] n);
    return (int'(n) + 2) / 2;
  endfunction

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_a <= '0; qp_a <= 1'b0; seen_a <= 1'b0; len_a <= '0;
    end else begin
      cp_a   <= cur_a;
      qp_a   <= q_a;
      len_a  <= (q_a != qp_a) ? 8'd1 : ((len_a == 8'hFF) ? len_a : len_a + 8'd1);
      seen_a <= (cur_a == '0) ? 1'b0 : ((q_a != qp_a) ? 1'b1 : seen_a);
    end
  end

  always_ff @(posedge pll_clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_b <= '0; qp_b <= 1'b0; seen_b <= 1'b0; len_b <= '0;
    end else begin
      cp_b   <= cur_b;
      qp_b   <= q_b;
      len_b  <= (q_b != qp_b) ? 8'd1 : ((len_b == 8'hFF) ? len_b : len_b + 8'd1);
      seen_b <= (cur_b == '0) ? 1'b0 : ((q_b != qp_b) ? 1'b1 : seen_b);
    end
  end

  always @(negedge bus_clk) begin
    if (!rst_n) assert_reset_low_a_R1: assert (!clk_a_out);
  end

  always @(negedge pll_clk) begin
    if (!rst_n) assert_reset_low_b_R1: assert (!clk_b_out);
  end

  assert_a_run_R3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (seen_a && (q_a != qp_a)) |-> (int'(len_a) == int'(cp_a)));

  assert_b_run_R5: assert property (@(posedge pll_clk) disable iff (!rst_n)
    (seen_b && (q_b != qp_b)) |-> (int'(len_b) == (qp_b ? hi_of(cp_b) : lo_of(cp_b))));

  assert_cur_a_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (cur_a != cp_a) |-> ((cp_a == '0) || (qp_a && !q_a)));

  assert_cur_b_R7: assert property (@(posedge pll_clk) disable iff (!rst_n)
    (cur_b != cp_b) |-> ((cp_b == '0) || (qp_b && !q_b)));

endmodule

bind clkdiv_pair clkdiv_pair_chk #(.W(W)) u_chk (
  .bus_clk(bus_clk), .pll_clk(pll_clk), .rst_n(rst_n),
  .cur_a(cur_a), .cur_b(cur_b), .q_a(q_a), .q_b(q_b),
  .clk_a_out(clk_a_out), .clk_b_out(clk_b_out)
);

// File: tb/tb_clkdiv_pair.sv
`timescale 1ns/1ps
module tb_clkdiv_pair;

  logic       bus_clk = 1'b0;
  logic       pll_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [3:0] div_a   = 4'd0;
  logic [3:0] div_b   = 4'd0;
  logic       clk_a_out, clk_b_out;
  realtime    pll_half = 3.5;
  int         n_checks = 0;
  int         n_fail   = 0;

  always #2.5 bus_clk = ~bus_clk;
  always #(pll_half) pll_clk = ~pll_clk;

  clkdiv_pair dut (
    .bus_clk(bus_clk), .pll_clk(pll_clk), .rst_n(rst_n),
    .div_a(div_a), .div_b(div_b),
    .clk_a_out(clk_a_out), .clk_b_out(clk_b_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic smp(input bit b, output logic v);
    if (b) begin @(negedge pll_clk); v = clk_b_out; end
    else   begin @(negedge bus_clk); v = clk_a_out; end
  endtask

  task automatic follow(input bit b, input logic lvl, output int n);
    logic v;
    n = 0;
    smp(b, v);
    while (v === lvl && n < 200) begin n++; smp(b, v); end
  endtask

  task automatic find(input bit b, input logic lvl);
    logic v;
    int g = 0;
    smp(b, v);
    while (v !== lvl && g < 200) begin g++; smp(b, v); end
  endtask

  task automatic settle(input bit b);
    logic v;
    for (int i = 0; i < 80; i++) smp(b, v);
  endtask

  task automatic runs(input bit b, output int hi, output int lo);
    int k;
    find(b, 1'b0);
    find(b, 1'b1);
    follow(b, 1'b1, k); hi = k + 1;
    follow(b, 1'b0, k); lo = k + 1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 14; i++) begin
      #0.9;
      chk("R1", "outputs low in reset", int'({clk_a_out, clk_b_out}), 0);
    end
    div_a = 4'd3;
    div_b = 4'd2;
    #3.1;
    chk("R1", "outputs low in reset, nonzero settings", int'({clk_a_out, clk_b_out}), 0);
  endtask

  task automatic t_first_period();
    int k;
    @(negedge bus_clk);
    rst_n = 1'b1;
    follow(1'b0, 1'b0, k);
    chk("R9", "low cycles before first rise", k, 3);
  endtask

  task automatic t_bypass_a();
    div_a = 4'd0;
    settle(1'b0);
    for (int i = 0; i < 3; i++) begin
      @(posedge bus_clk); #1;
      chk("R2", "bypass A high", int'(clk_a_out), 1);
      @(negedge bus_clk); #1;
      chk("R2", "bypass A low", int'(clk_a_out), 0);
    end
  endtask

  task automatic t_bypass_b();
    div_b = 4'd0;
    settle(1'b1);
    for (int i = 0; i < 3; i++) begin
      @(posedge pll_clk); #1;
      chk("R4", "bypass B high", int'(clk_b_out), 1);
      @(negedge pll_clk); #1;
      chk("R4", "bypass B low", int'(clk_b_out), 0);
    end
  endtask

  task automatic t_div_a(input int n);
    int hi, lo;
    div_a = 4'(n);
    settle(1'b0);
    runs(1'b0, hi, lo);
    chk("R3", $sformatf("A high, N=%0d", n), hi, n);
    chk("R3", $sformatf("A low, N=%0d", n), lo, n);
  endtask

  task automatic t_div_b(input int n);
    int hi, lo;
    div_b = 4'(n);
    settle(1'b1);
    runs(1'b1, hi, lo);
    chk("R5", $sformatf("B high, N=%0d", n), hi, (n + 2) / 2);
    chk("R5", $sformatf("B low, N=%0d", n), lo, (n + 1) / 2);
  endtask

  task automatic t_scale();
    realtime t0, t1;
    div_a = 4'd3;
    settle(1'b0);
    @(posedge clk_a_out); t0 = $realtime;
    @(posedge clk_a_out); t1 = $realtime;
    chk("R6", "A period ps", int'((t1 - t0) * 1000.0), 30000);
    div_b = 4'd4;
    settle(1'b1);
    @(posedge clk_b_out); t0 = $realtime;
    @(posedge clk_b_out); t1 = $realtime;
    chk("R6", "B period ps at 7 ns source", int'((t1 - t0) * 1000.0), 35000);
    pll_half = 5.0;
    settle(1'b1);
    @(posedge clk_b_out); t0 = $realtime;
    @(posedge clk_b_out); t1 = $realtime;
    chk("R6", "B period ps at 10 ns source", int'((t1 - t0) * 1000.0), 50000);
  endtask

  task automatic t_mid_change_a();
    int k;
    div_a = 4'd4;
    settle(1'b0);
    find(1'b0, 1'b1);
    follow(1'b0, 1'b1, k);
    div_a = 4'd2;
    follow(1'b0, 1'b0, k); chk("R7", "A low of period in progress", k + 1, 4);
    follow(1'b0, 1'b1, k); chk("R7", "A high of period in progress", k + 1, 4);
    follow(1'b0, 1'b0, k); chk("R7", "A low after reload", k + 1, 2);
    follow(1'b0, 1'b1, k); chk("R7", "A high after reload", k + 1, 2);
  endtask

  task automatic t_mid_change_b();
    int k;
    div_b = 4'd5;
    settle(1'b1);
    find(1'b1, 1'b1);
    follow(1'b1, 1'b1, k);
    div_b = 4'd2;
    follow(1'b1, 1'b0, k); chk("R7", "B low of period in progress", k + 1, 3);
    follow(1'b1, 1'b1, k); chk("R7", "B high of period in progress", k + 1, 3);
    follow(1'b1, 1'b0, k); chk("R7", "B low after reload", k + 1, 1);
    follow(1'b1, 1'b1, k); chk("R7", "B high after reload", k + 1, 2);
  endtask

  task automatic t_edge_change_a();
    logic v;
    int k;
    div_a = 4'd3;
    settle(1'b0);
    find(1'b0, 1'b0);
    find(1'b0, 1'b1);
    smp(1'b0, v); chk("R8", "A second high sample", int'(v), 1);
    smp(1'b0, v); chk("R8", "A last high sample", int'(v), 1);
    div_a = 4'd5;
    follow(1'b0, 1'b1, k); chk("R8", "A falls on reload edge", k, 0);
    follow(1'b0, 1'b0, k); chk("R8", "A low uses new value", k + 1, 5);
    follow(1'b0, 1'b1, k); chk("R8", "A high uses new value", k + 1, 5);
  endtask

  task automatic t_edge_change_b();
    logic v;
    int k;
    div_b = 4'd3;
    settle(1'b1);
    find(1'b1, 1'b0);
    find(1'b1, 1'b1);
    smp(1'b1, v); chk("R8", "B last high sample", int'(v), 1);
    div_b = 4'd6;
    follow(1'b1, 1'b1, k); chk("R8", "B falls on reload edge", k, 0);
    follow(1'b1, 1'b0, k); chk("R8", "B low uses new value", k + 1, 3);
    follow(1'b1, 1'b1, k); chk("R8", "B high uses new value", k + 1, 4);
  endtask

  initial begin
    t_reset();
    t_first_period();
    t_bypass_a();
    t_bypass_b();
    t_div_a(1);
    t_div_a(2);
    t_div_a(7);
    t_div_a(15);
    t_div_b(1);
    t_div_b(2);
    t_div_b(5);
    t_div_b(14);
    t_div_b(15);
    t_mid_change_a();
    t_mid_change_b();
    t_edge_change_a();
    t_edge_change_b();
    t_scale();
    t_bypass_b();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule